// File: doc/BRIEF.md
# Clock Generator Configuration Target (SMBus style)

This block is the serial configuration target of a clock generator. A two-wire controller reaches eight configuration bytes through it. The block decodes those bytes into four output-enable bits, a spread-spectrum on/off bit, a spread-depth select and two test-mode bits. The wire inputs are sampled with the block's own clock. SDA is pulled low through an open-drain enable, and the block never holds SCL low.

Each access opens with a command byte. Its top bit picks single-byte access or block access. The next two bits are a chip-select field, and the low five bits hold a register offset. A block write sends a byte count before its data. A block read answers with the count first and then the registers from index 0 upward. The last byte is a fixed, read-only identity byte.

Top module: `clkcfg_smb_target`

## Requirements
- R1: The block acknowledges only the 7-bit address 0x69 (0xD2 write, 0xD3 read). Any other address gets a NACK in the address acknowledge slot, and the rest of that transfer is ignored.
- R2: In a command byte, bit 7 = 1 selects single-byte access and bit 7 = 0 selects block access. Bits 6:5 must be 00. Otherwise the command byte gets a NACK and no register changes.
- R3: A byte write (command with bit 7 = 1, offset in bits 4:0, then one data byte) stores the data in the register at that offset and acknowledges every byte. Configuration outputs change only as the result of an accepted write.
- R4: A byte read (command, repeated start, 0xD3) returns the register at the command's offset, MSB first. Offsets 8 to 31 read as 0x00.
- R5: A block write (command 0x00, count N, data) stores its data bytes in registers 0, 1, 2 and upward. Data bytes past N get a NACK and are not stored. Bytes aimed at index 7 or higher are acknowledged and discarded.
- R6: A block read (command 0x00, repeated start, 0xD3) returns 0x08 first, then registers 0, 1, 2 and upward. It ends when the controller NACKs a byte, which may happen after any byte.
- R7: After reset the registers hold: byte0 0x7C, byte1 0x01, byte2 0xEA, byte3 0xAF, byte4 0x00, byte5 0x00, byte6 0x13.
- R8: Byte 7 always reads 0x01 (revision 0 in bits 7:4, vendor 1 in bits 3:0). Writes to it are acknowledged and have no effect.
- R9: Output map: out_en[3:0] = byte0 bits 6:3, where 1 enables a clock pair and 0 sets it to high impedance. ss_depth = byte2 bit 7 (0 = 0.35 %, 1 = 0.5 % down). ss_on = byte2 bit 2. tst_src = byte6 bit 7. tst_on = byte6 bit 6.
- R10: The SDA drive changes only while synchronised SCL is low. It is released in idle, after a START and during the controller's acknowledge slot. A STOP returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low |
| out_en | output | 4 | Per-pair clock output enables |
| ss_on | output | 1 | Spread-spectrum enable |
| ss_depth | output | 1 | Spread depth select |
| tst_src | output | 1 | Test output source select |
| tst_on | output | 1 | Test mode entry |

## Verification
The bench builds the block with its default parameters: device address 0x69 and a two-stage pin synchroniser. One bus bit lasts 20 clocks, so every synchroniser and edge-detect delay fits inside a quarter bit. Those defaults let the bench reach the address match and mismatch, the chip-select rejection, block writes that run past the count or past index 7, and full and early-ended block reads, all at the ports.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  localparam int NREG  = 8;
  localparam int OFFW  = 5;
  localparam logic [7:0] ID_BYTE = 8'h01;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RXACK,
    PH_TX,
    PH_TXACK
  } phase_t;

  typedef enum logic [1:0] {
    FLD_ADDR,
    FLD_CMD,
    FLD_CNT,
    FLD_DATA
  } field_t;

  function automatic logic [7:0] reg_default(input int idx);
    logic [7:0] v;
    case (idx)
      0:       v = 8'h7C;
      1:       v = 8'h01;
      2:       v = 8'hEA;
      3:       v = 8'hAF;
      6:       v = 8'h13;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/clkcfg_pinsync.sv
module clkcfg_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [OFFW-1:0]           waddr,
  input  logic [7:0]                wdata,
  input  logic [OFFW-1:0]           raddr,
  output logic [7:0]                rdata,
  output logic [NREG-2:0][7:0]      rw_q
);

  for (genvar g = 0; g < NREG - 1; g++) begin : g_byte
    logic hit;
    assign hit = we && (waddr == OFFW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rw_q[g] <= reg_default(g);
      else if (hit) rw_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NREG - 1; i++) begin
      if (raddr == OFFW'(i)) rdata = rw_q[i];
    end
    if (raddr == OFFW'(NREG - 1)) rdata = ID_BYTE;
  end

endmodule

// File: rtl/clkcfg_proto.sv
module clkcfg_proto
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [7:0]      rdata,
  output logic [OFFW-1:0] raddr,
  output logic            we,
  output logic [OFFW-1:0] waddr,
  output logic [7:0]      wdata,
  output logic            sda_oe,
  output phase_t          phase_o
);

  phase_t          ph, ph_n;
  field_t          fld, fld_n;
  logic [3:0]      bcnt, bcnt_n;
  logic [7:0]      sr, sr_n;
  logic [OFFW-1:0] ptr, ptr_n, ptr_inc;
  logic [7:0]      remain, remain_n;
  logic            blk, blk_n, sent, sent_n, rd, rd_n, mack, mack_n, oe, oe_n;
  logic            ack_c;
  logic [7:0]      tx_c;

  assign ptr_inc = (ptr == {OFFW{1'b1}}) ? ptr : ptr + 1'b1;
  assign tx_c    = (blk && !sent) ? 8'(NREG) : rdata;
  assign raddr   = ptr;
  assign waddr   = ptr;
  assign wdata   = sr;

  always_comb begin
    ph_n = ph;  fld_n = fld;  bcnt_n = bcnt;  sr_n = sr;  ptr_n = ptr;
    remain_n = remain;  blk_n = blk;  sent_n = sent;  rd_n = rd;
    mack_n = mack;  oe_n = oe;  we = 1'b0;  ack_c = 1'b0;
    if (stop_det) begin
      ph_n = PH_IDLE;
      oe_n = 1'b0;
    end else if (start_det) begin
      ph_n   = PH_RX;
      fld_n  = FLD_ADDR;
      bcnt_n = 4'd0;
      oe_n   = 1'b0;
    end else begin
      case (ph)
        PH_RX: begin
          if (scl_rise && bcnt != 4'd8) begin
            sr_n   = {sr[6:0], sda_s};
            bcnt_n = bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            rd_n = 1'b0;
            case (fld)
              FLD_ADDR: if (sr[7:1] == DEV_ADDR) begin
                ack_c = 1'b1;
                if (sr[0]) rd_n = 1'b1;
                else       fld_n = FLD_CMD;
              end
              FLD_CMD: if (sr[6:5] == 2'b00) begin
                ack_c  = 1'b1;
                blk_n  = ~sr[7];
                ptr_n  = sr[7] ? sr[OFFW-1:0] : '0;
                fld_n  = sr[7] ? FLD_DATA : FLD_CNT;
                sent_n = 1'b0;
              end
              FLD_CNT: begin
                ack_c    = 1'b1;
                remain_n = sr;
                fld_n    = FLD_DATA;
              end
              default: if (!blk || remain != 8'd0) begin
                ack_c = 1'b1;
                we    = 1'b1;
                ptr_n = ptr_inc;
                if (blk) remain_n = remain - 8'd1;
              end
            endcase
            if (ack_c) begin
              ph_n = PH_RXACK;
              oe_n = 1'b1;
            end else begin
              ph_n = PH_IDLE;
            end
          end
        end
        PH_RXACK: if (scl_fall) begin
          bcnt_n = 4'd0;
          if (rd) begin
            ph_n = PH_TX;
            sr_n = tx_c;
            oe_n = ~tx_c[7];
            if (blk && !sent) sent_n = 1'b1;
            else              ptr_n  = ptr_inc;
          end else begin
            ph_n = PH_RX;
            oe_n = 1'b0;
          end
        end
        PH_TX: if (scl_fall) begin
          if (bcnt == 4'd7) begin
            oe_n = 1'b0;
            ph_n = PH_TXACK;
          end else begin
            sr_n   = {sr[6:0], 1'b0};
            bcnt_n = bcnt + 4'd1;
            oe_n   = ~sr[6];
          end
        end
        PH_TXACK: begin
          if (scl_rise) mack_n = ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              ph_n   = PH_TX;
              bcnt_n = 4'd0;
              sr_n   = tx_c;
              oe_n   = ~tx_c[7];
              if (blk && !sent) sent_n = 1'b1;
              else              ptr_n  = ptr_inc;
            end else begin
              ph_n = PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE;  fld <= FLD_ADDR;  bcnt <= 4'd0;  sr <= 8'h00;
      ptr <= '0;  remain <= 8'h00;  blk <= 1'b0;  sent <= 1'b0;
      rd <= 1'b0;  mack <= 1'b0;  oe <= 1'b0;
    end else begin
      ph <= ph_n;  fld <= fld_n;  bcnt <= bcnt_n;  sr <= sr_n;
      ptr <= ptr_n;  remain <= remain_n;  blk <= blk_n;  sent <= sent_n;
      rd <= rd_n;  mack <= mack_n;  oe <= oe_n;
    end
  end

  assign sda_oe  = oe;
  assign phase_o = ph;

endmodule

// File: rtl/clkcfg_smb_target.sv
module clkcfg_smb_target
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [3:0] out_en,
  output logic       ss_on,
  output logic       ss_depth,
  output logic       tst_src,
  output logic       tst_on
);

  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic we;
  logic [OFFW-1:0] raddr, waddr;
  logic [7:0] wdata, rdata;
  logic [NREG-2:0][7:0] rw_q;
  phase_t phase;
  logic [7:0] cfg_vec;

  clkcfg_pinsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  clkcfg_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
    .clk(clk), .rst_n(rst_sync_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rdata(rdata), .raddr(raddr), .we(we), .waddr(waddr), .wdata(wdata),
    .sda_oe(sda_oe), .phase_o(phase)
  );

  clkcfg_regbank u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata), .rw_q(rw_q)
  );

  assign out_en   = rw_q[0][6:3];
  assign ss_depth = rw_q[2][7];
  assign ss_on    = rw_q[2][2];
  assign tst_src  = rw_q[6][7];
  assign tst_on   = rw_q[6][6];
  assign cfg_vec  = {out_en, ss_on, ss_depth, tst_src, tst_on};

endmodule

// File: rtl/clkcfg_smb_chk.sv
module clkcfg_smb_chk
  import clkcfg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       start_det,
  input logic       sda_oe,
  input phase_t     phase,
  input logic [7:0] cfg
);

  // R10: SDA drive moves only while SCL is low
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R10: released when idle
  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe);

  // R10: released after a START
  p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> !sda_oe);

  // R6: controller acknowledge slot is never driven
  p_mack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TXACK) |-> !sda_oe);

  // R3: configuration changes only on a byte completion at an SCL fall
  p_cfg_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> $past(scl_fall));

endmodule

bind clkcfg_smb_target clkcfg_smb_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_det(start_det), .sda_oe(sda_oe), .phase(phase), .cfg(cfg_vec)
);

// File: tb/test_clkcfg_smb_target.sv
`timescale 1ns/1ps
module test_clkcfg_smb_target;

  localparam real Q = 25.0;

  logic clk, rst_n, scl, sda_m;
  logic sda_oe, ss_on, ss_depth, tst_src, tst_on;
  logic [3:0] out_en;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  clkcfg_smb_target i_clkcfg_smb_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .out_en(out_en), .ss_on(ss_on), .ss_depth(ss_depth),
    .tst_src(tst_src), .tst_on(tst_on)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;
  logic [7:0] mdl [8];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got;
  event       got_ev;
  bit         done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares every byte read from the target
  always @(got_ev) begin
    if (exp_q.size() == 0) chk("R6 unexpected read byte", got, 8'hxx);
    else chk(tag_q.pop_front(), got, exp_q.pop_front());
  end

  task automatic push_exp(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic bus_start();
    sda_m = 1; #(Q); scl = 1; #(Q); sda_m = 0; #(Q); scl = 0; #(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; #(Q); scl = 1; #(Q); sda_m = 1; #(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; #(Q); scl = 1; #(2*Q); scl = 0; #(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1; #(Q); scl = 1; #(Q); b = sda_line; #(Q); scl = 0; #(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(input logic last);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    got = v;
    -> got_ev;
    put_bit(last);
  endtask

  task automatic byte_wr(input logic [4:0] off, input logic [7:0] d, input string req);
    logic a;
    bus_start();
    wr_byte(8'hD2, a); chk({req, " addr ack"}, a, 1);
    wr_byte({3'b100, off}, a); chk({req, " cmd ack"}, a, 1);
    wr_byte(d, a); chk({req, " data ack"}, a, 1);
    bus_stop();
    if (off < 7) mdl[off] = d;
  endtask

  task automatic byte_rd(input logic [4:0] off, input string req);
    logic a;
    bus_start();
    wr_byte(8'hD2, a); chk({req, " addr ack"}, a, 1);
    wr_byte({3'b100, off}, a); chk({req, " cmd ack"}, a, 1);
    bus_start();
    wr_byte(8'hD3, a); chk({req, " raddr ack"}, a, 1);
    push_exp((off < 8) ? mdl[off] : 8'h00, {req, " read data"});
    rd_byte(1'b1);
    bus_stop();
  endtask

  task automatic blk_rd(input int nbytes, input string req);
    logic a;
    bus_start();
    wr_byte(8'hD2, a); chk({req, " addr ack"}, a, 1);
    wr_byte(8'h00, a); chk({req, " cmd ack"}, a, 1);
    bus_start();
    wr_byte(8'hD3, a); chk({req, " raddr ack"}, a, 1);
    for (int i = 0; i < nbytes; i++) begin
      push_exp((i == 0) ? 8'h08 : mdl[i-1], $sformatf("%s byte %0d", req, i));
      rd_byte(i == nbytes - 1);
    end
    bus_stop();
  endtask

  task automatic chk_ports(input string req);
    #(Q);
    chk({req, " out_en"}, out_en, mdl[0][6:3]);
    chk({req, " ss_on"}, ss_on, mdl[2][2]);
    chk({req, " ss_depth"}, ss_depth, mdl[2][7]);
    chk({req, " tst_src"}, tst_src, mdl[6][7]);
    chk({req, " tst_on"}, tst_on, mdl[6][6]);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=hung expected=done");
      report();
    end
  end

  initial begin
    logic a;
    byte unsigned bw [9];
    mdl = '{8'h7C, 8'h01, 8'hEA, 8'hAF, 8'h00, 8'h00, 8'h13, 8'h01};
    scl = 1; sda_m = 1; rst_n = 0;
    #(100); rst_n = 1; #(100);

    // R7 / R9 reset state at the ports, R10 released
    chk("R10 sda_oe after reset", sda_oe, 0);
    chk("R7 out_en reset", out_en, 4'hF);
    chk("R7 ss_depth reset", ss_depth, 1);
    chk_ports("R7 R9 reset");

    // R8 identity byte, R4 and R7 defaults by byte read
    byte_rd(5'd7, "R8 id read");
    byte_rd(5'd2, "R4 R7 read byte2");
    byte_rd(5'd6, "R4 R7 read byte6");
    byte_rd(5'd3, "R4 R7 read byte3");
    byte_rd(5'd12, "R4 offset above range");

    // R3 byte write and R9 decode
    byte_wr(5'd2, 8'h6E, "R3 write byte2");
    chk_ports("R3 R9 after byte2");
    byte_rd(5'd2, "R3 readback byte2");

    // R1 wrong address
    bus_start();
    wr_byte(8'hD4, a); chk("R1 foreign address nack", a, 0);
    bus_stop();
    chk("R1 R10 released after foreign address", sda_oe, 0);

    // R2 chip-select nonzero
    bus_start();
    wr_byte(8'hD2, a); chk("R2 addr ack", a, 1);
    wr_byte(8'hA2, a); chk("R2 bad chip select nack", a, 0);
    bus_stop();
    byte_rd(5'd2, "R2 byte2 unchanged");

    // R8 write to read-only byte
    byte_wr(5'd7, 8'hFF, "R8 write id");
    byte_rd(5'd7, "R8 id still 01");

    // R6 full block read
    blk_rd(9, "R6 full block");

    // R5 block write of three bytes
    bus_start();
    wr_byte(8'hD2, a); chk("R5 addr ack", a, 1);
    wr_byte(8'h00, a); chk("R5 cmd ack", a, 1);
    wr_byte(8'h03, a); chk("R5 count ack", a, 1);
    bw[0] = 8'h24; bw[1] = 8'h55; bw[2] = 8'h3B;
    for (int i = 0; i < 3; i++) begin
      wr_byte(bw[i], a); chk("R5 data ack", a, 1);
      mdl[i] = bw[i];
    end
    bus_stop();
    chk_ports("R5 R9 after block write 3");
    chk("R9 out_en from 0x24", out_en, 4'b0100);

    // R5 data past count is refused
    bus_start();
    wr_byte(8'hD2, a); wr_byte(8'h00, a); wr_byte(8'h01, a);
    wr_byte(8'h5A, a); chk("R5 first byte within count ack", a, 1);
    mdl[0] = 8'h5A;
    wr_byte(8'hC3, a); chk("R5 byte beyond count nack", a, 0);
    bus_stop();
    byte_rd(5'd1, "R5 byte1 not written past count");

    // R5 block write running past index 7
    bw = '{8'h78, 8'h11, 8'hEE, 8'h22, 8'h33, 8'h44, 8'hC0, 8'h99, 8'h77};
    bus_start();
    wr_byte(8'hD2, a); wr_byte(8'h00, a); wr_byte(8'h09, a);
    chk("R5 count 9 ack", a, 1);
    for (int i = 0; i < 9; i++) begin
      wr_byte(bw[i], a); chk($sformatf("R5 long data %0d ack", i), a, 1);
      if (i < 7) mdl[i] = bw[i];
    end
    bus_stop();
    chk_ports("R5 R9 after long block write");
    chk("R9 tst_on set", tst_on, 1);

    // R6 early end and full verify, R8 id unchanged
    blk_rd(3, "R6 early stop");
    blk_rd(9, "R6 R8 final block");
    chk("R10 released at end", sda_oe, 0);
    chk("R6 scoreboard drained", exp_q.size(), 0);

    done = 1;
    report();
  end

endmodule